// File: doc/BRIEF.md
# Frame-grabber sync decoder

This block sits on the receive side of a parallel camera video interface and turns the camera's three timing strobes into clean per-pixel bookkeeping. Every pixel clock it samples a frame strobe, a line strobe, a data-qualifier strobe and one pixel word. It outputs the pixel word with a qualified valid flag, the column and row of that pixel, and single-cycle start-of-frame, end-of-line and end-of-frame markers. All outputs are registered, so each output reflects the inputs sampled one clock edge earlier.

The decoder tolerates loosely behaved cameras. The frame and line strobes may rise in the same cycle. The frame strobe may fall before the last line has finished. The line strobe may toggle between frames. The data qualifier may be meaningless. The frame strobe is latched only while the line strobe is low, or at the cycle a line starts, so a frame cannot end in the middle of a line. Line activity outside a frame is discarded. A configuration input selects whether the data qualifier is honoured.

Top module: `fg_sync_decoder`

## Requirements
- R1: While `rst` is high and on the first edge after it falls, all outputs are zero. After reset the block waits for a frame start. A line already in progress when reset was applied is not accepted until the line strobe has been seen low.
- R2: The latched frame state is updated from `fv_in` only on edges where `lv_in` is low or `lv_in` is rising. If `fv_in` falls while an accepted line is active, that line keeps producing pixels to its end, and end-of-frame follows only once `lv_in` is low.
- R3: A line is accepted on a rising `lv_in` edge when `fv_in` is high on that edge. This includes the same edge on which `fv_in` rises, and it holds after any number of idle cycles between the frame and line strobes.
- R4: `col_o` is 0 for the first qualified pixel of each accepted line and increases by 1 for each further qualified pixel. It holds its value on cycles without a qualified pixel, and it is set to 0 when a line is accepted.
- R5: `row_o` is 0 for the first accepted line after a frame start and increases by 1 for each further accepted line of the same frame.
- R6: With `cfg_use_dval`=1, a pixel is qualified only when `dv_in`=1 during an accepted line. With `cfg_use_dval`=0, every cycle of an accepted line is a qualified pixel, whatever `dv_in` is.
- R7: `dv_in` never affects line acceptance, line end or the frame state. A line whose `dv_in` is low at its start and end is still accepted, counted in `row_o` and ended with `eol_o`.
- R8: Line strobe activity while no frame is active gives no `pix_valid_o` and no `eol_o`, and it leaves `col_o` and `row_o` unchanged.
- R9: `sof_o` pulses together with the first qualified pixel of a frame, with `col_o`=0.
- R10: `eol_o` pulses on the edge after `lv_in` is first sampled low at the end of an accepted line.
- R11: `eof_o` pulses on the edge after the latched frame state goes from 1 to 0.
- R12: `pix_o` equals `pix_in` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_use_dval | input | 1 | 1: qualify pixels with dv_in; 0: ignore dv_in |
| fv_in | input | 1 | Frame strobe from the camera |
| lv_in | input | 1 | Line strobe from the camera |
| dv_in | input | 1 | Data-qualifier strobe from the camera |
| pix_in | input | DATA_W | Pixel data word |
| pix_o | output | DATA_W | Registered pixel data word |
| pix_valid_o | output | 1 | Qualified pixel on pix_o |
| col_o | output | COL_W | Column of the current pixel |
| row_o | output | ROW_W | Row of the current line |
| sof_o | output | 1 | First qualified pixel of a frame |
| eol_o | output | 1 | Accepted line has ended |
| eof_o | output | 1 | Frame has ended |

## Verification
A stuck or wrongly cleared frame latch shows at the ports within one line. It appears either as an early `eof_o` in the middle of a line whose frame strobe dropped, or as accepted pixels from line toggles outside any frame. A wrong armed state shows at the next accepted line as `row_o` not returning to 0 or `sof_o` missing. A column counter fault shows on the second qualified pixel of a line, which must read 1. The stimulus covers a frame strobe dropped mid-line, simultaneous strobe rises, a long strobe-to-line gap, lines with no qualified data, and reset in the middle of a line.

// File: rtl/fg_sync_pkg.sv
package fg_sync_pkg;

  // Per-cycle events decoded from the camera strobes
  typedef struct packed {
    logic line_start;  // accepted rising line strobe
    logic first_line;  // accepted line is the first of its frame
    logic pix_ok;      // qualified pixel this cycle
    logic line_end;    // accepted line has just ended
    logic frame_end;   // latched frame state is clearing
  } fg_evt_t;

endpackage

// File: rtl/fg_sync_ctrl.sv
module fg_sync_ctrl
  import fg_sync_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cfg_use_dval,
  input  logic    fv_in,
  input  logic    lv_in,
  input  logic    dv_in,
  output fg_evt_t evt
);

  logic fv_lat;   // latched frame state
  logic lv_q;     // previous line strobe
  logic armed;    // waiting for the first line of a frame
  logic in_line;  // an accepted line is running

  logic lv_rise, fv_upd, fv_nxt, fv_rise, armed_eff, line_on, dv_ok;

  always_comb begin
    lv_rise   = lv_in & ~lv_q;
    // frame strobe only taken while no line runs, or when one starts
    fv_upd    = ~lv_in | lv_rise;
    fv_nxt    = fv_upd ? fv_in : fv_lat;
    fv_rise   = fv_nxt & ~fv_lat;
    armed_eff = armed | fv_rise;
    line_on   = (lv_rise & fv_in) | (in_line & lv_in);
    dv_ok     = cfg_use_dval ? dv_in : 1'b1;

    evt.line_start = lv_rise & fv_in;
    evt.first_line = lv_rise & fv_in & armed_eff;
    evt.pix_ok     = line_on & dv_ok;
    evt.line_end   = in_line & ~lv_in;
    evt.frame_end  = fv_lat & ~fv_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fv_lat  <= 1'b0;
      lv_q    <= 1'b1;  // treat a high line strobe at reset as mid-line
      armed   <= 1'b1;
      in_line <= 1'b0;
    end else begin
      fv_lat  <= fv_nxt;
      lv_q    <= lv_in;
      armed   <= (lv_rise & fv_in) ? 1'b0 : armed_eff;
      in_line <= line_on;
    end
  end

endmodule

// File: rtl/fg_sync_cnt.sv
module fg_sync_cnt
  import fg_sync_pkg::*;
#(
  parameter int COL_W = 12,
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  fg_evt_t          evt,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o
);

  localparam logic [COL_W-1:0] COL_ONE = COL_W'(1);
  localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);

  logic [COL_W-1:0] col_cnt;  // index of the next qualified pixel

  always_ff @(posedge clk) begin
    if (rst) begin
      col_o   <= '0;
      col_cnt <= '0;
      row_o   <= '0;
    end else if (evt.line_start) begin
      col_o   <= '0;
      col_cnt <= evt.pix_ok ? COL_ONE : '0;
      row_o   <= evt.first_line ? '0 : row_o + ROW_ONE;
    end else if (evt.pix_ok) begin
      col_o   <= col_cnt;
      col_cnt <= col_cnt + COL_ONE;
    end
  end

endmodule

// File: rtl/fg_sync_out.sv
module fg_sync_out
  import fg_sync_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  fg_evt_t           evt,
  input  logic [DATA_W-1:0] pix_in,
  output logic [DATA_W-1:0] pix_o,
  output logic              pix_valid_o,
  output logic              sof_o,
  output logic              eol_o,
  output logic              eof_o
);

  logic sof_pend;  // frame started, first pixel not yet seen
  logic sof_eff;

  assign sof_eff = evt.first_line | sof_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_o       <= '0;
      pix_valid_o <= 1'b0;
      sof_o       <= 1'b0;
      eol_o       <= 1'b0;
      eof_o       <= 1'b0;
      sof_pend    <= 1'b0;
    end else begin
      pix_o       <= pix_in;
      pix_valid_o <= evt.pix_ok;
      sof_o       <= evt.pix_ok & sof_eff;
      sof_pend    <= sof_eff & ~evt.pix_ok;
      eol_o       <= evt.line_end;
      eof_o       <= evt.frame_end;
    end
  end

endmodule

// File: rtl/fg_sync_decoder.sv
module fg_sync_decoder
  import fg_sync_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COL_W  = 12,
  parameter int ROW_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_use_dval,
  input  logic              fv_in,
  input  logic              lv_in,
  input  logic              dv_in,
  input  logic [DATA_W-1:0] pix_in,
  output logic [DATA_W-1:0] pix_o,
  output logic              pix_valid_o,
  output logic [COL_W-1:0]  col_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              sof_o,
  output logic              eol_o,
  output logic              eof_o
);

  fg_evt_t evt;

  fg_sync_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cfg_use_dval (cfg_use_dval),
    .fv_in        (fv_in),
    .lv_in        (lv_in),
    .dv_in        (dv_in),
    .evt          (evt)
  );

  fg_sync_cnt #(.COL_W(COL_W), .ROW_W(ROW_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .evt   (evt),
    .col_o (col_o),
    .row_o (row_o)
  );

  fg_sync_out #(.DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .evt         (evt),
    .pix_in      (pix_in),
    .pix_o       (pix_o),
    .pix_valid_o (pix_valid_o),
    .sof_o       (sof_o),
    .eol_o       (eol_o),
    .eof_o       (eof_o)
  );

endmodule

// File: rtl/fg_sync_decoder_chk.sv
module fg_sync_decoder_chk #(
  parameter int COL_W = 12,
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_use_dval,
  input logic             fv_in,
  input logic             lv_in,
  input logic             dv_in,
  input logic             pix_valid_o,
  input logic [COL_W-1:0] col_o,
  input logic [ROW_W-1:0] row_o,
  input logic             sof_o,
  input logic             eol_o,
  input logic             eof_o
);

  AST_SOF_FIRST_COL: assert property (@(posedge clk) disable iff (rst)
    sof_o |-> (pix_valid_o && col_o == '0)); // R9

  AST_PIX_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
    pix_valid_o |-> $past(lv_in)); // R8

  AST_DVAL_QUALIFIES: assert property (@(posedge clk) disable iff (rst)
    (pix_valid_o && $past(cfg_use_dval)) |-> $past(dv_in)); // R6

  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    (col_o != $past(col_o)) |-> (col_o == '0 || col_o == COL_W'($past(col_o) + 1'b1))); // R4

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
    (row_o != $past(row_o)) |-> (row_o == '0 || row_o == ROW_W'($past(row_o) + 1'b1))); // R5

  AST_EOL_AFTER_LV_LOW: assert property (@(posedge clk) disable iff (rst)
    eol_o |-> !$past(lv_in)); // R10

  AST_EOF_AFTER_FV_LOW: assert property (@(posedge clk) disable iff (rst)
    eof_o |-> !$past(fv_in)); // R11

endmodule

bind fg_sync_decoder fg_sync_decoder_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_use_dval (cfg_use_dval),
  .fv_in        (fv_in),
  .lv_in        (lv_in),
  .dv_in        (dv_in),
  .pix_valid_o  (pix_valid_o),
  .col_o        (col_o),
  .row_o        (row_o),
  .sof_o        (sof_o),
  .eol_o        (eol_o),
  .eof_o        (eof_o)
);

// File: tb/fg_sync_decoder_tb.sv
module fg_sync_decoder_tb;

  localparam int DATA_W = 16;
  localparam int COL_W  = 12;
  localparam int ROW_W  = 12;
  localparam int NV     = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_use_dval = 1'b1;
  logic              fv_in = 1'b0, lv_in = 1'b0, dv_in = 1'b0;
  logic [DATA_W-1:0] pix_in = '0;
  logic [DATA_W-1:0] pix_o;
  logic              pix_valid_o, sof_o, eol_o, eof_o;
  logic [COL_W-1:0]  col_o;
  logic [ROW_W-1:0]  row_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fg_sync_decoder #(.DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_use_dval(cfg_use_dval),
    .fv_in(fv_in), .lv_in(lv_in), .dv_in(dv_in), .pix_in(pix_in),
    .pix_o(pix_o), .pix_valid_o(pix_valid_o), .col_o(col_o), .row_o(row_o),
    .sof_o(sof_o), .eol_o(eol_o), .eof_o(eof_o)
  );

  // {fv,lv,dv,use_dv}[31:28] data[27:12] valid[11] col[10:7] row[6:3] {sof,eol,eof}[2:0]
  localparam logic [31:0] VEC [NV] = '{
    {4'b0001, 16'h0000, 1'b0, 4'd0, 4'd0, 3'b000},  // idle
    {4'b0111, 16'h0001, 1'b0, 4'd0, 4'd0, 3'b000},  // line outside frame
    {4'b0001, 16'h0002, 1'b0, 4'd0, 4'd0, 3'b000},
    {4'b1111, 16'hA000, 1'b1, 4'd0, 4'd0, 3'b100},  // frame+line rise together
    {4'b1111, 16'hA001, 1'b1, 4'd1, 4'd0, 3'b000},
    {4'b1101, 16'hA002, 1'b0, 4'd1, 4'd0, 3'b000},  // dv gap
    {4'b1111, 16'hA003, 1'b1, 4'd2, 4'd0, 3'b000},
    {4'b1001, 16'h0003, 1'b0, 4'd2, 4'd0, 3'b010},  // line end
    {4'b1001, 16'h0004, 1'b0, 4'd2, 4'd0, 3'b000},
    {4'b1101, 16'h0005, 1'b0, 4'd0, 4'd1, 3'b000},  // line 2 starts, dv low
    {4'b1111, 16'hB001, 1'b1, 4'd0, 4'd1, 3'b000},
    {4'b0111, 16'hB002, 1'b1, 4'd1, 4'd1, 3'b000},  // frame strobe drops mid-line
    {4'b0111, 16'hB003, 1'b1, 4'd2, 4'd1, 3'b000},
    {4'b0001, 16'h0006, 1'b0, 4'd2, 4'd1, 3'b011},  // line and frame end
    {4'b0111, 16'h0007, 1'b0, 4'd2, 4'd1, 3'b000},  // toggle between frames
    {4'b0001, 16'h0008, 1'b0, 4'd2, 4'd1, 3'b000},
    {4'b1001, 16'h0009, 1'b0, 4'd2, 4'd1, 3'b000},  // new frame arms
    {4'b1001, 16'h000A, 1'b0, 4'd2, 4'd1, 3'b000},
    {4'b1100, 16'hC000, 1'b1, 4'd0, 4'd0, 3'b100},  // dv ignored mode
    {4'b1100, 16'hC001, 1'b1, 4'd1, 4'd0, 3'b000},
    {4'b1010, 16'h000B, 1'b0, 4'd1, 4'd0, 3'b010},
    {4'b1110, 16'hC100, 1'b1, 4'd0, 4'd1, 3'b000},
    {4'b1000, 16'h000C, 1'b0, 4'd0, 4'd1, 3'b010},
    {4'b0000, 16'h000D, 1'b0, 4'd0, 4'd1, 3'b001}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // drive away from the active edge, sample just after the edge that took the inputs
  task automatic apply(input logic fv, input logic lv, input logic dv,
                       input logic ud, input logic [DATA_W-1:0] d);
    @(negedge clk);
    fv_in = fv; lv_in = lv; dv_in = dv; cfg_use_dval = ud; pix_in = d;
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", int'(pix_valid_o), 0);
    check("R1 col in reset", int'(col_o), 0);
    check("R1 row in reset", int'(row_o), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      apply(v[31], v[30], v[29], v[28], v[27:12]);
      check("R6 valid", int'(pix_valid_o), int'(v[11]));
      check("R4 col", int'(col_o), int'(v[10:7]));
      check("R5 row", int'(row_o), int'(v[6:3]));
      check("R9 sof", int'(sof_o), int'(v[2]));
      check("R10 eol", int'(eol_o), int'(v[1]));
      check("R11 eof", int'(eof_o), int'(v[0]));
      check("R12 data", int'(pix_o), int'(v[27:12]));
    end

    // R1: reset in the middle of a line
    apply(1'b1, 1'b1, 1'b1, 1'b1, 16'h0100);
    apply(1'b1, 1'b1, 1'b1, 1'b1, 16'h0101);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 valid at reset", int'(pix_valid_o), 0);
    check("R1 col at reset", int'(col_o), 0);
    check("R1 eof at reset", int'(eof_o), 0);
    @(negedge clk);
    rst = 1'b0;
    apply(1'b1, 1'b1, 1'b1, 1'b1, 16'h0102);
    check("R1 no pixel from line running at reset", int'(pix_valid_o), 0);
    apply(1'b1, 1'b0, 1'b0, 1'b1, 16'h0103);
    check("R1 no eol for unaccepted line", int'(eol_o), 0);

    // R3: long gap from frame strobe to first line
    repeat (300) apply(1'b1, 1'b0, 1'b0, 1'b1, 16'h0000);
    apply(1'b1, 1'b1, 1'b1, 1'b1, 16'hD000);
    check("R3 first line accepted after gap", int'(pix_valid_o), 1);
    check("R3 row", int'(row_o), 0);
    check("R3 sof", int'(sof_o), 1);

    // R2: frame strobe drops while the line runs
    apply(1'b0, 1'b1, 1'b1, 1'b1, 16'hD001);
    check("R2 pixel continues after frame drop", int'(pix_valid_o), 1);
    check("R2 col", int'(col_o), 1);
    apply(1'b1, 1'b1, 1'b1, 1'b1, 16'hD002);
    apply(1'b0, 1'b1, 1'b1, 1'b1, 16'hD003);
    check("R2 col keeps counting", int'(col_o), 3);
    check("R2 no early eof", int'(eof_o), 0);
    apply(1'b0, 1'b0, 1'b0, 1'b1, 16'h0000);
    check("R2 eol at line end", int'(eol_o), 1);
    check("R2 eof with line end", int'(eof_o), 1);

    // R8: line toggles with no frame
    for (int k = 0; k < 4; k++) begin
      apply(1'b0, 1'b1, 1'b1, 1'b1, 16'h0E00);
      check("R8 no pixel outside frame", int'(pix_valid_o), 0);
      apply(1'b0, 1'b0, 1'b1, 1'b1, 16'h0E01);
      check("R8 no eol outside frame", int'(eol_o), 0);
    end
    check("R8 col held", int'(col_o), 3);
    check("R8 row held", int'(row_o), 0);

    // R7: line with the data qualifier low throughout
    apply(1'b1, 1'b0, 1'b0, 1'b1, 16'h0000);
    apply(1'b1, 1'b1, 1'b0, 1'b1, 16'h0F00);
    check("R7 line accepted, col reset", int'(col_o), 0);
    check("R7 no qualified pixel", int'(pix_valid_o), 0);
    apply(1'b1, 1'b1, 1'b0, 1'b1, 16'h0F01);
    apply(1'b1, 1'b0, 1'b0, 1'b1, 16'h0000);
    check("R7 eol without dv", int'(eol_o), 1);
    apply(1'b1, 1'b1, 1'b1, 1'b1, 16'h0F10);
    check("R7 row counted empty line", int'(row_o), 1);
    check("R9 sof on first qualified pixel", int'(sof_o), 1);
    check("R9 sof col", int'(col_o), 0);
    apply(1'b0, 1'b0, 1'b0, 1'b1, 16'h0000);
    check("R11 eof", int'(eof_o), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule